// File: doc/BRIEF.md
# Biquinary Decade Counter with Set-Nine

This block is a decade counter made of two sections, each with its own count clock. One section divides by two (output bit QA). The other divides by five (output bits QD, QC and QB, held as a binary value from 0 to 4). Each section steps on a falling edge of its count clock. Both count clocks are sampled in one system clock domain. Falling edges are found there through a short synchroniser and a compare with the previous sample.

Two control pairs act on both sections. Each pair is AND-ed, so a single high pin does nothing. When both set-nine pins are high, the outputs load the value nine. When both clear pins are high, the outputs clear to zero, but set-nine wins over clear. While either control is active, counting stops. The control pins are taken to be synchronous to the system clock. Each one acts at the next system clock edge.

The `MODE` parameter sets how the two sections are joined inside the block:
- **BCD mode:** the wrap of the divide-by-two section steps the divide-by-five section. The outputs then follow 8421 BCD.
- **Biquinary mode:** the wrap of the divide-by-five section steps the divide-by-two section. The outputs then follow 5421 code.
- **Independent mode:** each section follows only its own pin.

Top module: `bq_decade_counter`

## Requirements
- R1: After reset, q (bit 3 = QD, bit 2 = QC, bit 1 = QB, bit 0 = QA) is 4'b0000. In every mode, q[3:1] never exceeds 4.
- R2: With nine_1 and nine_2 both high at a system clock edge, q is 4'b1001 after that edge, whatever the clear pins do.
- R3: With clr_1 and clr_2 both high and the set-nine pair not both high, q is 4'b0000 after the next system clock edge.
- R4: A section steps only on a high-to-low transition of its count pin. Its output changes at the third system clock edge after the pin falls. A rising transition changes nothing. A fall seen while R2 or R3 is active is lost.
- R5: In BCD mode, falls on cnt_a make q run 0,1,...,9 and back to 0, as an unsigned binary number.
- R6: In biquinary mode, falls on cnt_b make {q[0],q[3],q[2],q[1]} run 0,1,2,3,4,8,9,10,11,12 and back to 0.
- R7: In independent mode, a fall on cnt_a toggles q[0] only. A fall on cnt_b steps q[3:1] through 0..4 and back to 0, leaving q[0] as it was.
- R8: Only one high pin of a pair (clear or set-nine) has no effect: counting goes on as normal.
- R9: The count pin that the chain replaces is ignored: cnt_b in BCD mode and cnt_a in biquinary mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_a | input | 1 | Count pin of the divide-by-two section |
| cnt_b | input | 1 | Count pin of the divide-by-five section |
| clr_1 | input | 1 | Clear request, first half of the pair |
| clr_2 | input | 1 | Clear request, second half of the pair |
| nine_1 | input | 1 | Set-nine request, first half of the pair |
| nine_2 | input | 1 | Set-nine request, second half of the pair |
| q | output | 4 | Count bits QD..QA |

## Verification
The hardest case to reach is a wrap in one section that steps the other section through the internal chain. The bench must also show that the replaced pin is ignored in that same mode. To do this, the bench runs three copies, one per mode, from the same pins. Random pulses on both count pins, mixed with one-pin and two-pin control requests, bring every copy through its wrap points many times. A bench model of each mode is kept for comparison. A directed case drops cnt_a while the clear pair is held, then releases the clear before cnt_a rises. This shows that a swallowed edge and the rising edge after it both leave the count unchanged.

// File: rtl/bq_pkg.sv
package bq_pkg;
  typedef enum logic [1:0] {
    CHAIN_BCD  = 2'd0,
    CHAIN_5421 = 2'd1,
    CHAIN_NONE = 2'd2
  } chain_e;
endpackage

// File: rtl/bq_fall_detect.sv
module bq_fall_detect #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic fall
);
  logic [STAGES-1:0] sync_q, sync_d;
  logic              prev_q, prev_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], pin};
    prev_d = sync_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign fall = prev_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/bq_div2.sv
module bq_div2 (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic load_nine,
  input  logic clear,
  output logic bit_q,
  output logic at_top
);
  logic bit_d;

  always_comb begin
    bit_d = bit_q;
    if (load_nine)  bit_d = 1'b1;
    else if (clear) bit_d = 1'b0;
    else if (step)  bit_d = ~bit_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bit_q <= 1'b0;
    else        bit_q <= bit_d;
  end

  assign at_top = bit_q;
endmodule

// File: rtl/bq_div5.sv
module bq_div5 #(
  parameter int MODULUS = 5,
  localparam int W = $clog2(MODULUS)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         load_nine,
  input  logic         clear,
  output logic [W-1:0] cnt_q,
  output logic         at_top
);
  localparam logic [W-1:0] TOP = W'(MODULUS - 1);
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_nine)  cnt_d = TOP;
    else if (clear) cnt_d = '0;
    else if (step)  cnt_d = (cnt_q == TOP) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign at_top = (cnt_q == TOP);
endmodule

// File: rtl/bq_decade_counter.sv
module bq_decade_counter #(
  parameter bq_pkg::chain_e MODE = bq_pkg::CHAIN_BCD,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cnt_a,
  input  logic       cnt_b,
  input  logic       clr_1,
  input  logic       clr_2,
  input  logic       nine_1,
  input  logic       nine_2,
  output logic [3:0] q
);
  localparam logic A_FROM_PIN = (MODE != bq_pkg::CHAIN_5421);
  localparam logic B_FROM_PIN = (MODE != bq_pkg::CHAIN_BCD);
  localparam logic A_FROM_B   = (MODE == bq_pkg::CHAIN_5421);
  localparam logic B_FROM_A   = (MODE == bq_pkg::CHAIN_BCD);

  logic       fall_a, fall_b;
  logic       nine_act, clr_act, run;
  logic       pin_a, pin_b, step_a, step_b;
  logic       top_a, top_b, bit_a;
  logic [2:0] cnt_b5;

  bq_fall_detect #(.STAGES(SYNC_STAGES)) u_edge_a (
    .clk(clk), .rst_n(rst_n), .pin(cnt_a), .fall(fall_a));
  bq_fall_detect #(.STAGES(SYNC_STAGES)) u_edge_b (
    .clk(clk), .rst_n(rst_n), .pin(cnt_b), .fall(fall_b));

  always_comb begin
    nine_act = nine_1 & nine_2;
    clr_act  = clr_1 & clr_2 & ~nine_act;
    run      = ~nine_act & ~clr_act;
    pin_a    = run & fall_a;
    pin_b    = run & fall_b;
    // chain carry is taken from state, so it lands in the same cycle
    step_a   = (A_FROM_PIN & pin_a) | (A_FROM_B & pin_b & top_b);
    step_b   = (B_FROM_PIN & pin_b) | (B_FROM_A & pin_a & top_a);
  end

  bq_div2 u_sec_a (
    .clk(clk), .rst_n(rst_n), .step(step_a), .load_nine(nine_act),
    .clear(clr_act), .bit_q(bit_a), .at_top(top_a));

  bq_div5 #(.MODULUS(5)) u_sec_b (
    .clk(clk), .rst_n(rst_n), .step(step_b), .load_nine(nine_act),
    .clear(clr_act), .cnt_q(cnt_b5), .at_top(top_b));

  assign q = {cnt_b5, bit_a};
endmodule

// File: rtl/bq_decade_checker.sv
module bq_decade_checker #(
  parameter bq_pkg::chain_e MODE = bq_pkg::CHAIN_BCD
) (
  input logic       clk,
  input logic       rst_n,
  input logic       clr_1,
  input logic       clr_2,
  input logic       nine_1,
  input logic       nine_2,
  input logic       fall_a,
  input logic       fall_b,
  input logic [3:0] q
);
  a_r1_b_range: assert property (@(posedge clk) disable iff (!rst_n)
    q[3:1] <= 3'd4);

  a_r2_nine_load: assert property (@(posedge clk) disable iff (!rst_n)
    (nine_1 && nine_2) |=> (q == 4'b1001));

  a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_1 && clr_2 && !(nine_1 && nine_2)) |=> (q == 4'b0000));

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!(clr_1 && clr_2) && !(nine_1 && nine_2) && !fall_a && !fall_b)
      |=> $stable(q));

  a_r5_bcd_range: assert property (@(posedge clk) disable iff (!rst_n)
    (MODE == bq_pkg::CHAIN_BCD) |-> (q <= 4'd9));
endmodule

bind bq_decade_counter bq_decade_checker #(.MODE(MODE)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_1(clr_1), .clr_2(clr_2),
  .nine_1(nine_1), .nine_2(nine_2), .fall_a(fall_a), .fall_b(fall_b),
  .q(q));

// File: tb/tb_bq_decade_counter.sv
module tb_bq_decade_counter;
  logic clk = 1'b0;
  logic rst_n, cnt_a, cnt_b, clr_1, clr_2, nine_1, nine_2;
  logic [3:0] q_bcd, q_bq, q_ind;
  int checks = 0, errors = 0;
  int ma[3], mb[3];

  always #5 clk = ~clk;

  bq_decade_counter #(.MODE(bq_pkg::CHAIN_BCD)) dut (
    .clk(clk), .rst_n(rst_n), .cnt_a(cnt_a), .cnt_b(cnt_b), .clr_1(clr_1),
    .clr_2(clr_2), .nine_1(nine_1), .nine_2(nine_2), .q(q_bcd));
  bq_decade_counter #(.MODE(bq_pkg::CHAIN_5421)) dut_bq (
    .clk(clk), .rst_n(rst_n), .cnt_a(cnt_a), .cnt_b(cnt_b), .clr_1(clr_1),
    .clr_2(clr_2), .nine_1(nine_1), .nine_2(nine_2), .q(q_bq));
  bq_decade_counter #(.MODE(bq_pkg::CHAIN_NONE)) dut_ind (
    .clk(clk), .rst_n(rst_n), .cnt_a(cnt_a), .cnt_b(cnt_b), .clr_1(clr_1),
    .clr_2(clr_2), .nine_1(nine_1), .nine_2(nine_2), .q(q_ind));

  function automatic logic [3:0] exp_q(int m);
    return {3'(mb[m]), 1'(ma[m])};
  endfunction

  task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic chk_all(string req);
    chk({req, " bcd"}, q_bcd, exp_q(0));
    chk({req, " 5421"}, q_bq, exp_q(1));
    chk({req, " indep"}, q_ind, exp_q(2));
  endtask

  task automatic model_fall_a();
    if (ma[0] == 1) begin ma[0] = 0; mb[0] = (mb[0] + 1) % 5; end
    else ma[0] = 1;
    ma[2] ^= 1;
  endtask

  task automatic model_fall_b();
    if (mb[1] == 4) begin mb[1] = 0; ma[1] ^= 1; end
    else mb[1]++;
    mb[2] = (mb[2] + 1) % 5;
  endtask

  task automatic pulse_a();
    @(negedge clk); cnt_a = 1'b0; model_fall_a();
    repeat (4) @(negedge clk);
    cnt_a = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_b();
    @(negedge clk); cnt_b = 1'b0; model_fall_b();
    repeat (4) @(negedge clk);
    cnt_b = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic ctl(logic c1, logic c2, logic n1, logic n2);
    @(negedge clk);
    clr_1 = c1; clr_2 = c2; nine_1 = n1; nine_2 = n2;
    repeat (2) @(negedge clk);
    for (int m = 0; m < 3; m++) begin
      if (n1 && n2) begin ma[m] = 1; mb[m] = 4; end
      else if (c1 && c2) begin ma[m] = 0; mb[m] = 0; end
    end
    clr_1 = 0; clr_2 = 0; nine_1 = 0; nine_2 = 0;
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int sv;
    int r;
    sv = $urandom(32'h5eed1234);
    rst_n = 0; cnt_a = 1; cnt_b = 1; clr_1 = 0; clr_2 = 0; nine_1 = 0; nine_2 = 0;
    for (int m = 0; m < 3; m++) begin ma[m] = 0; mb[m] = 0; end
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk_all("R1 reset");
    // R5: BCD sweep as unsigned number
    for (int i = 1; i <= 10; i++) begin
      pulse_a();
      chk("R5 bcd sweep", q_bcd, 4'(i % 10));
    end
    // R9: cnt_b ignored in BCD mode
    pulse_b();
    chk("R9 bcd ignores cnt_b", q_bcd, exp_q(0));
    ctl(1, 1, 0, 0);
    // R6: 5421 sweep
    for (int i = 1; i <= 10; i++) begin
      pulse_b();
      chk("R6 5421 sweep", {q_bq[0], q_bq[3:1]},
          4'((i % 10) < 5 ? (i % 10) : (i % 10) + 3));
    end
    // R9: cnt_a ignored in 5421 mode
    pulse_a();
    chk("R9 5421 ignores cnt_a", q_bq, exp_q(1));
    // R7: independent sections
    chk("R7 indep", q_ind, exp_q(2));
    // R2: nine wins over clear
    ctl(1, 1, 1, 1);
    chk_all("R2 nine over clear");
    // R3: clear
    ctl(1, 1, 0, 1);
    chk_all("R3 clear");
    // R8: single pins have no effect
    ctl(1, 0, 1, 0);
    pulse_a();
    chk_all("R8 single pins");
    // R4: fall while clear held is lost; rise after release changes nothing
    @(negedge clk); clr_1 = 1; clr_2 = 1; cnt_a = 0;
    repeat (5) @(negedge clk);
    for (int m = 0; m < 3; m++) begin ma[m] = 0; mb[m] = 0; end
    clr_1 = 0; clr_2 = 0;
    repeat (2) @(negedge clk);
    cnt_a = 1;
    repeat (5) @(negedge clk);
    chk_all("R4 lost fall and rise");
    // R4: latency, output changes at third edge after fall
    @(negedge clk); cnt_a = 0;
    repeat (2) @(negedge clk);
    chk("R4 not yet", q_ind, 4'b0000);
    @(negedge clk);
    chk("R4 third edge", q_ind, 4'b0001);
    model_fall_a();
    repeat (2) @(negedge clk); cnt_a = 1; repeat (4) @(negedge clk);
    // random mix
    for (int k = 0; k < 300; k++) begin
      r = int'($urandom_range(0, 9));
      if (r < 4) pulse_a();
      else if (r < 8) pulse_b();
      else if (r == 8) ctl(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      else ctl($urandom_range(0, 3) == 0, 1, 0, 0);
      chk_all("R7 random mix");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule